// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block stands in for a keyboard hanging off one channel of a serial controller. The host writes command bytes toward the keyboard, and the block answers the few commands a keyboard understands by loading fixed reply sequences into a small receive queue. Key events arrive as already-translated 7-bit codes with a press/release flag. They enter the same queue, with bit 7 marking a release. The channel's receive data register reads the head of the queue, and each data read pops one byte.

Two filters shape the byte stream. The byte that follows a set-LED command is LED data, so the block swallows it instead of decoding it. Lock keys are filtered so that one full toggle of a lock key reaches the host as a single press and a single release. Replies flush the queue first and then enqueue one byte per clock. A command that arrives while a reply is still being loaded waits in a one-entry slot until the reply is complete.

Top module: `kbd_responder`

## Requirements
- R1: The queue holds DEPTH (default 16) bytes in circular order. Fullness is judged at the start of a cycle, and a byte offered to a full queue is dropped without disturbing the bytes already held.
- R2: Command 0x01 empties the queue in the cycle it is decoded. From the following clock it enqueues 0xFF, 0x04 and 0x7F, in that order, one byte per clock.
- R3: After command 0x0E, the next command byte accepted is discarded without being decoded and leaves the queue unchanged.
- R4: Commands 0x07 and 0x0F empty the queue and then enqueue 0xFE and 0x21, one per clock. Every other command byte leaves the queue unchanged.
- R5: An accepted key event enqueues {key_release, key_code[6:0]}, so bit 7 is 1 for a release and 0 for a press.
- R6: Each lock key (default codes 0x77 and 0x62) has a 2-bit state that starts at 0. A press XORs in 1 and is dropped if the result is 2. A release XORs in 2 and is dropped if the result is 3. Press, release, press, release therefore yields only the first press and the last release.
- R7: While the queue is non-empty, rx_avail is 1 and rx_data shows the head byte. rd_en pops the head, and the next byte, if any, appears after that clock. When the queue is empty, rx_avail is 0 and rx_data is 0, and a read changes nothing.
- R8: A command byte is accepted only when tx_en is 1 while cmd_valid is 1. With tx_en at 0 the byte has no effect.
- R9: A command accepted while a reply is loading is held in a one-entry slot and decoded once the reply completes. A further command arriving while the slot is full is dropped. A key event in a cycle where a reply byte would be written goes into the queue first, and the reply resumes on the next clock. A key event in the flush cycle lands ahead of the reply.
- R10: Reset empties the queue, clears the LED-skip state, clears the command slot and clears every lock-key state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; commands are taken only while high |
| cmd_valid | input | 1 | Host writes a command byte this cycle |
| cmd_byte | input | 8 | Command byte |
| key_valid | input | 1 | Key event this cycle |
| key_code | input | 7 | Translated key code |
| key_release | input | 1 | 1 = release, 0 = press |
| rd_en | input | 1 | Host reads the receive data register this cycle |
| rx_avail | output | 1 | Queue holds at least one byte |
| rx_data | output | 8 | Head byte, or 0 when the queue is empty |

## Verification
The bench targets the places where ordering goes wrong:
- **LED-byte skip.** A design that decoded the byte after 0x0E would flush the queue and load a second reply.
- **Stalled and deferred replies.** A key event that lands mid-reply must appear ahead of the remaining reply bytes. A set-LED command held in the slot must still swallow the next command. A design that dropped or reordered these would show a different byte sequence at the read port.
- **Lock-key toggle.** A double toggle must produce exactly two bytes. A wrong XOR or drop test would leak an extra press or release.
- **Overflow.** Twenty key events sent into the 16-entry queue must return exactly the first sixteen. A design that overwrote the oldest bytes would return a different set.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
   localparam logic [7:0] CMD_RESET    = 8'h01;
   localparam logic [7:0] CMD_SET_LED  = 8'h0E;
   localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
   localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;

   typedef enum logic {RPL_RESET = 1'b0, RPL_LAYOUT = 1'b1} reply_kind_t;

   function automatic logic [7:0] reply_byte(reply_kind_t k, logic [1:0] idx);
      logic [7:0] b;
      if (k == RPL_RESET) begin
         case (idx)
            2'd0:    b = 8'hFF;
            2'd1:    b = 8'h04;
            default: b = 8'h7F;
         endcase
      end else begin
         b = (idx == 2'd0) ? 8'hFE : 8'h21;
      end
      return b;
   endfunction

   function automatic logic [1:0] reply_last(reply_kind_t k);
      return (k == RPL_RESET) ? 2'd2 : 2'd1;
   endfunction
endpackage

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter #(
   parameter logic [6:0] LOCK_CODE = 7'h77
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_valid,
   input  logic [6:0] key_code,
   input  logic       key_release,
   output logic       drop
);
   logic [1:0] state_q;
   logic [1:0] state_n;
   logic       hit;

   assign hit     = key_valid && (key_code == LOCK_CODE);
   assign state_n = state_q ^ (key_release ? 2'd2 : 2'd1);
   assign drop    = hit && (key_release ? (state_n == 2'd3) : (state_n == 2'd2));

   always_ff @(posedge clk) begin
      if (!rst_n)   state_q <= 2'd0;
      else if (hit) state_q <= state_n;
   end

   // R6: a press that follows an unreported release is swallowed
   a_r6_second_press_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !key_release && state_q == 2'd3 |-> drop);
   // R6: a first press is always reported
   a_r6_first_press_kept: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !key_release && state_q == 2'd0 |-> !drop);
endmodule

// File: rtl/kbd_reply_seq.sv
module kbd_reply_seq
   import kbd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_fire,
   input  logic [7:0] cmd_byte,
   input  logic       stall,
   output logic       flush,
   output logic       wr_en,
   output logic [7:0] wr_data
);
   logic        busy_q, busy_n;
   reply_kind_t kind_q, kind_n;
   logic [1:0]  idx_q, idx_n;
   logic        skip_q, skip_n;
   logic        pend_v_q, pend_v_n;
   logic [7:0]  pend_b_q, pend_b_n;
   logic        src_v;
   logic [7:0]  src_b;

   assign src_v = !busy_q && (pend_v_q || cmd_fire);
   assign src_b = pend_v_q ? pend_b_q : cmd_byte;

   always_comb begin
      flush    = 1'b0;
      wr_en    = 1'b0;
      wr_data  = 8'h00;
      busy_n   = busy_q;
      kind_n   = kind_q;
      idx_n    = idx_q;
      skip_n   = skip_q;
      pend_v_n = pend_v_q;
      pend_b_n = pend_b_q;
      if (busy_q) begin
         if (!stall) begin
            wr_en   = 1'b1;
            wr_data = reply_byte(kind_q, idx_q);
            if (idx_q == reply_last(kind_q)) busy_n = 1'b0;
            else                             idx_n  = idx_q + 2'd1;
         end
         if (cmd_fire && !pend_v_q) begin
            pend_v_n = 1'b1;
            pend_b_n = cmd_byte;
         end
      end else begin
         if (pend_v_q) begin
            pend_v_n = cmd_fire;
            pend_b_n = cmd_byte;
         end
         if (src_v) begin
            if (skip_q) begin
               skip_n = 1'b0;
            end else begin
               case (src_b)
                  CMD_RESET: begin
                     flush  = 1'b1;
                     busy_n = 1'b1;
                     kind_n = RPL_RESET;
                     idx_n  = 2'd0;
                  end
                  CMD_SET_LED: skip_n = 1'b1;
                  CMD_LAYOUT_A, CMD_LAYOUT_B: begin
                     flush  = 1'b1;
                     busy_n = 1'b1;
                     kind_n = RPL_LAYOUT;
                     idx_n  = 2'd0;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         kind_q   <= RPL_RESET;
         idx_q    <= 2'd0;
         skip_q   <= 1'b0;
         pend_v_q <= 1'b0;
         pend_b_q <= 8'h00;
      end else begin
         busy_q   <= busy_n;
         kind_q   <= kind_n;
         idx_q    <= idx_n;
         skip_q   <= skip_n;
         pend_v_q <= pend_v_n;
         pend_b_q <= pend_b_n;
      end
   end

   // R9: a stalled reply keeps its position
   a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && stall |=> busy_q && $stable(idx_q));
   // R9: a command during a reply is parked in the free slot
   a_r9_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && cmd_fire && !pend_v_q |=> pend_v_q);
   // R3: a skipped byte starts no reply and clears the skip state
   a_r3_skip_consumes: assert property (@(posedge clk) disable iff (!rst_n)
      src_v && skip_q |=> !busy_q && !skip_q);
   // R2: a flush always begins a reply at its first byte
   a_r2_flush_starts: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> busy_q && idx_q == 2'd0);
endmodule

// File: rtl/kbd_rx_fifo.sv
module kbd_rx_fifo #(
   parameter int DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   output logic       rx_avail,
   output logic [7:0] rx_data
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wptr_q, rptr_q, waddr;
   logic [CNT_W-1:0] count_q;
   logic             do_wr, do_rd;

   assign do_wr = wr_en && (flush || count_q != FULL);
   assign do_rd = rd_en && !flush && count_q != '0;
   assign waddr = flush ? '0 : wptr_q;

   always_ff @(posedge clk) begin
      if (do_wr) mem[waddr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
      end else if (flush) begin
         rptr_q  <= '0;
         wptr_q  <= do_wr ? PTR_W'(1) : '0;
         count_q <= do_wr ? CNT_W'(1) : '0;
      end else begin
         if (do_wr) wptr_q <= wptr_q + PTR_W'(1);
         if (do_rd) rptr_q <= rptr_q + PTR_W'(1);
         count_q <= count_q + (do_wr ? CNT_W'(1) : '0) - (do_rd ? CNT_W'(1) : '0);
      end
   end

   assign rx_avail = (count_q != '0);
   assign rx_data  = rx_avail ? mem[rptr_q] : 8'h00;

   // R1: the count never passes the depth
   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL);
   // R1: a write into a full queue without a read leaves it full
   a_r1_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !flush && count_q == FULL && wr_en && !rd_en |=> count_q == FULL);
   // R7: reading an empty queue changes nothing
   a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      !flush && !wr_en && count_q == '0 && rd_en |=> count_q == '0);
   // R2: a flush leaves at most the coincident byte
   a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> count_q <= CNT_W'(1));
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder #(
   parameter int                DEPTH      = 16,
   parameter int                NUM_LOCKS  = 2,
   parameter logic [NUM_LOCKS*7-1:0] LOCK_CODES = {7'h62, 7'h77}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_byte,
   input  logic       key_valid,
   input  logic [6:0] key_code,
   input  logic       key_release,
   input  logic       rd_en,
   output logic       rx_avail,
   output logic [7:0] rx_data
);
   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "DEPTH must be a power of two of at least 4");
      assert (NUM_LOCKS >= 1)
         else $fatal(1, "NUM_LOCKS must be at least 1");
   end

   logic [NUM_LOCKS-1:0] lock_drop;
   logic                 key_wr;
   logic                 cmd_fire;
   logic                 flush, rep_wr;
   logic [7:0]           rep_data;
   logic                 q_wr;
   logic [7:0]           q_data;

   for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
      kbd_lock_filter #(.LOCK_CODE(LOCK_CODES[i*7 +: 7])) u_lock (
         .clk        (clk),
         .rst_n      (rst_n),
         .key_valid  (key_valid),
         .key_code   (key_code),
         .key_release(key_release),
         .drop       (lock_drop[i])
      );
   end

   assign key_wr   = key_valid && !(|lock_drop);
   assign cmd_fire = cmd_valid && tx_en;

   kbd_reply_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_fire(cmd_fire),
      .cmd_byte(cmd_byte),
      .stall   (key_wr),
      .flush   (flush),
      .wr_en   (rep_wr),
      .wr_data (rep_data)
   );

   assign q_wr   = key_wr || rep_wr;
   assign q_data = key_wr ? {key_release, key_code} : rep_data;

   kbd_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (q_wr),
      .wr_data (q_data),
      .rd_en   (rd_en),
      .rx_avail(rx_avail),
      .rx_data (rx_data)
   );

   // R5: key and reply writes never collide on the queue port
   a_r5_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
      !(key_wr && rep_wr));
   // R8: with transmit disabled no command starts a flush
   a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en && cmd_valid && !rx_avail && !key_valid |=> !rx_avail);
endmodule

// File: tb/sim_kbd_responder.sv
module sim_kbd_responder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b1;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       key_valid = 1'b0;
   logic [6:0] key_code = 7'h00;
   logic       key_release = 1'b0;
   logic       rd_en = 1'b0;
   logic       rx_avail;
   logic [7:0] rx_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   kbd_responder u0 (.*);

   localparam logic [2:0] OP_CMD = 3'd0, OP_CMDX = 3'd1, OP_PRESS = 3'd2,
                          OP_REL = 3'd3, OP_READ = 3'd4, OP_EMPTY = 3'd5;
   localparam int NV = 39;
   // {op, argument, expected byte, requirement number}
   localparam logic [22:0] VEC [NV] = '{
      {OP_EMPTY, 8'h00, 8'h00, 4'd7},
      {OP_CMD,   8'h01, 8'h00, 4'd2},   // R2 reset reply
      {OP_READ,  8'h00, 8'hFF, 4'd2},
      {OP_READ,  8'h00, 8'h04, 4'd2},
      {OP_READ,  8'h00, 8'h7F, 4'd2},
      {OP_EMPTY, 8'h00, 8'h00, 4'd7},
      {OP_CMD,   8'h07, 8'h00, 4'd4},   // R4 layout query
      {OP_READ,  8'h00, 8'hFE, 4'd4},
      {OP_READ,  8'h00, 8'h21, 4'd4},
      {OP_EMPTY, 8'h00, 8'h00, 4'd4},
      {OP_CMD,   8'h0F, 8'h00, 4'd4},
      {OP_READ,  8'h00, 8'hFE, 4'd4},
      {OP_READ,  8'h00, 8'h21, 4'd4},
      {OP_CMD,   8'h0E, 8'h00, 4'd3},   // R3 LED byte swallowed
      {OP_CMD,   8'h01, 8'h00, 4'd3},
      {OP_CMD,   8'h07, 8'h00, 4'd3},
      {OP_READ,  8'h00, 8'hFE, 4'd3},
      {OP_READ,  8'h00, 8'h21, 4'd3},
      {OP_EMPTY, 8'h00, 8'h00, 4'd3},
      {OP_CMD,   8'h55, 8'h00, 4'd4},   // R4 unknown ignored
      {OP_EMPTY, 8'h00, 8'h00, 4'd4},
      {OP_PRESS, 8'h1C, 8'h00, 4'd5},   // R5 press and release
      {OP_REL,   8'h1C, 8'h00, 4'd5},
      {OP_READ,  8'h00, 8'h1C, 4'd5},
      {OP_READ,  8'h00, 8'h9C, 4'd5},
      {OP_PRESS, 8'h77, 8'h00, 4'd6},   // R6 lock toggle
      {OP_REL,   8'h77, 8'h00, 4'd6},
      {OP_PRESS, 8'h77, 8'h00, 4'd6},
      {OP_REL,   8'h77, 8'h00, 4'd6},
      {OP_READ,  8'h00, 8'h77, 4'd6},
      {OP_READ,  8'h00, 8'hF7, 4'd6},
      {OP_EMPTY, 8'h00, 8'h00, 4'd6},
      {OP_PRESS, 8'h11, 8'h00, 4'd4},   // R4 flush drops older key
      {OP_CMD,   8'h07, 8'h00, 4'd4},
      {OP_READ,  8'h00, 8'hFE, 4'd4},
      {OP_READ,  8'h00, 8'h21, 4'd4},
      {OP_EMPTY, 8'h00, 8'h00, 4'd4},
      {OP_CMDX,  8'h01, 8'h00, 4'd8},   // R8 tx disabled
      {OP_EMPTY, 8'h00, 8'h00, 4'd8}
   };

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_cmd(logic [7:0] b, logic en, int wait_cyc);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_byte = b; tx_en = en;
      @(negedge clk);
      cmd_valid = 1'b0; tx_en = 1'b1;
      repeat (wait_cyc) @(negedge clk);
   endtask

   task automatic send_key(logic [6:0] c, logic rel);
      @(negedge clk);
      key_valid = 1'b1; key_code = c; key_release = rel;
      @(negedge clk);
      key_valid = 1'b0;
   endtask

   task automatic read_exp(logic [7:0] exp, string req);
      @(negedge clk);
      check(rx_avail == 1'b1 && rx_data == exp, req, {rx_avail, rx_data}, {1'b1, exp});
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic empty_exp(string req);
      @(negedge clk);
      check(rx_avail == 1'b0 && rx_data == 8'h00, req, {rx_avail, rx_data}, 0);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(rx_avail == 1'b0 && rx_data == 8'h00, req, {rx_avail, rx_data}, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      @(negedge clk);
      check(rx_avail == 1'b0 && rx_data == 8'h00, "R10 reset", {rx_avail, rx_data}, 0);

      for (int i = 0; i < NV; i++) begin
         logic [2:0] op;
         logic [7:0] arg, exp;
         string      req;
         op  = VEC[i][22:20];
         arg = VEC[i][19:12];
         exp = VEC[i][11:4];
         req = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
         case (op)
            OP_CMD:   send_cmd(arg, 1'b1, 5);
            OP_CMDX:  send_cmd(arg, 1'b0, 5);
            OP_PRESS: send_key(arg[6:0], 1'b0);
            OP_REL:   send_key(arg[6:0], 1'b1);
            OP_READ:  read_exp(exp, req);
            default:  empty_exp(req);
         endcase
      end

      // R1 overflow: twenty presses, only the first sixteen kept
      for (int k = 0; k < 20; k++) send_key(7'(k), 1'b0);
      for (int k = 0; k < 16; k++) read_exp(8'(k), "R1 overflow");
      empty_exp("R1 overflow tail");

      // R9 key event stalls a reply in progress
      @(negedge clk);
      cmd_valid = 1'b1; cmd_byte = 8'h01;
      @(negedge clk);
      cmd_valid = 1'b0; key_valid = 1'b1; key_code = 7'h05; key_release = 1'b0;
      @(negedge clk);
      key_valid = 1'b0;
      repeat (5) @(negedge clk);
      read_exp(8'h05, "R9 stall key");
      read_exp(8'hFF, "R9 stall");
      read_exp(8'h04, "R9 stall");
      read_exp(8'h7F, "R9 stall");
      empty_exp("R9 stall tail");

      // R9 set-LED deferred in slot still swallows the next command
      @(negedge clk);
      cmd_valid = 1'b1; cmd_byte = 8'h01;
      @(negedge clk);
      cmd_byte = 8'h0E;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (6) @(negedge clk);
      send_cmd(8'h07, 1'b1, 5);
      read_exp(8'hFF, "R9 deferred");
      read_exp(8'h04, "R9 deferred");
      read_exp(8'h7F, "R9 deferred");
      empty_exp("R9 deferred tail");

      // R10 reset clears a pending LED skip
      send_cmd(8'h0E, 1'b1, 1);
      do_reset();
      send_cmd(8'h07, 1'b1, 5);
      read_exp(8'hFE, "R10 skip cleared");
      read_exp(8'h21, "R10 skip cleared");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule